// File: doc/BRIEF.md
# Low-Resolution Framebuffer Video Scanner

This block produces 640x480, 60 Hz monitor timing from a single pixel-rate clock and fills the visible area from a small byte-per-pixel image of 160x120 picture elements. Every stored byte becomes a 4x4 square on screen, which gives a coarse but full-screen colour picture with 64 possible colours.

The image lives in an external memory with a synchronous read port. The scanner presents a read address and an enable during the cycle in which its raster counters reach a position. It captures the returned byte one cycle later. Each image row occupies its own 256-byte page above a fixed base address, and the column is the low address byte. Sync and colour are delayed so that they leave the block together, two clocks after the counter position they describe.

Top module: `vga_lowres_scan`

## Requirements
- R1: While reset is asserted and for the first two clocks after its release, hsync_n and vsync_n are high and red, green and blue are 0. The raster counters restart at column 0, line 0.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (800 by default) and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (525 by default). The outputs seen after clock edge k describe raster position k-2 counted from reset release.
- R3: hsync_n is low for H_SYNC clocks (96 by default), starting H_ACTIVE+H_FP clocks (656 by default) into each line, and is high otherwise.
- R4: vsync_n is low for V_SYNC whole lines (2 by default), starting at line V_ACTIVE+V_FP (490 by default), and is high otherwise.
- R5: red, green and blue are 0 whenever the position is outside the first H_ACTIVE columns of the first V_ACTIVE lines.
- R6: For an active position (column h, line v), mem_addr equals FB_BASE + (v/4)*ROW_STRIDE + (h/4), which is 0x0800 + (v/4)*0x100 + (h/4) by default. It is shown in the cycle in which the counters are at that position.
- R7: Each stored byte covers a 4x4 square of screen positions. mem_addr stays the same across the four columns of a group on the same line.
- R8: For an active position, red is bits [1:0], green is bits [3:2] and blue is bits [5:4] of the byte returned for its address. Bits [7:6] have no effect on any output.
- R9: mem_en is high exactly when the counters are at an active position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Read address for the framebuffer |
| mem_en | output | 1 | Read enable, high during active positions |
| mem_data | input | 8 | Byte returned one clock after the address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
Several properties are checked on every cycle. The horizontal counter wraps and steps by one, the line counter moves only at a line end, colour is blank two clocks after any inactive position, the address holds steady inside each 4-column group, and hsync falls only at the programmed column. The exact values need the bench's scenarios to show them. These are the byte-to-colour mapping, the page-per-row address arithmetic, the vertical sync lines and the two-clock alignment. The bench sweeps three whole frames of a shrunken timing configuration and the first three lines of the default one, against a memory whose upper bits vary.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  // Linear framebuffer address for a given image row and column.
  function automatic logic [31:0] fb_addr(input int base, input int stride,
                                          input int row, input int col);
    return 32'(base + row * stride + col);
  endfunction

  // Byte to colour: returns {blue, green, red}; upper two bits unused.
  function automatic logic [5:0] byte_to_rgb(input logic [7:0] b);
    return {b[5:4], b[3:2], b[1:0]};
  endfunction

endpackage

// File: rtl/vga_axis.sv
module vga_axis #(
  parameter int ACTIVE = 640,
  parameter int FP     = 16,
  parameter int SYNC   = 96,
  parameter int BP     = 48,
  parameter int W      = $clog2(ACTIVE + FP + SYNC + BP)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         active,
  output logic         sync_n
);
  localparam int TOTAL = ACTIVE + FP + SYNC + BP;
  localparam logic [W-1:0] POS_LAST   = W'(TOTAL - 1);
  localparam logic [W-1:0] POS_ACT    = W'(ACTIVE);
  localparam logic [W-1:0] SYNC_START = W'(ACTIVE + FP);
  localparam logic [W-1:0] SYNC_END   = W'(ACTIVE + FP + SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos <= '0;
    else if (step)
      pos <= (pos == POS_LAST) ? '0 : pos + W'(1);
  end

  assign last   = (pos == POS_LAST);
  assign active = (pos < POS_ACT);
  assign sync_n = !((pos >= SYNC_START) && (pos < SYNC_END));
endmodule

// File: rtl/vga_fetch.sv
module vga_fetch #(
  parameter int HW         = 10,
  parameter int VW         = 10,
  parameter int ADDR_W     = 16,
  parameter int FB_BASE    = 'h0800,
  parameter int ROW_STRIDE = 'h100,
  parameter int REP_LOG2   = 2
) (
  input  logic [HW-1:0]     h_pos,
  input  logic [VW-1:0]     v_pos,
  input  logic              px_active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en
);
  import vga_scan_pkg::*;

  logic [HW-1:0] col;
  logic [VW-1:0] row;
  logic [31:0]   lin;

  assign col      = h_pos >> REP_LOG2;
  assign row      = v_pos >> REP_LOG2;
  assign lin      = fb_addr(FB_BASE, ROW_STRIDE, int'(row), int'(col));
  assign mem_addr = lin[ADDR_W-1:0];
  assign mem_en   = px_active;
endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_in,
  input  logic       vs_in,
  input  logic       act_in,
  input  logic [7:0] mem_data,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [1:0] red,
  output logic [1:0] green,
  output logic [1:0] blue
);
  import vga_scan_pkg::*;

  logic       hs_d, vs_d, act_d;
  logic [5:0] rgb_next;

  // Stage aligned with the memory read cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d  <= 1'b1;
      vs_d  <= 1'b1;
      act_d <= 1'b0;
    end else begin
      hs_d  <= hs_in;
      vs_d  <= vs_in;
      act_d <= act_in;
    end
  end

  assign rgb_next = act_d ? byte_to_rgb(mem_data) : 6'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      red     <= 2'd0;
      green   <= 2'd0;
      blue    <= 2'd0;
    end else begin
      hsync_n <= hs_d;
      vsync_n <= vs_d;
      {blue, green, red} <= rgb_next;
    end
  end
endmodule

// File: rtl/vga_lowres_scan.sv
module vga_lowres_scan #(
  parameter int H_ACTIVE   = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  parameter int ADDR_W     = 16,
  parameter int FB_BASE    = 'h0800,
  parameter int ROW_STRIDE = 'h100,
  parameter int REP_LOG2   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en,
  input  logic [7:0]        mem_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [1:0]        red,
  output logic [1:0]        green,
  output logic [1:0]        blue
);
  localparam int HW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

  // Named internal events, visible to the bound checker.
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_wrap, v_last;
  logic          h_act, v_act, px_active;
  logic          h_sync_raw, v_sync_raw;

  vga_axis #(.ACTIVE(H_ACTIVE), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .W(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .pos(h_pos), .last(h_wrap), .active(h_act), .sync_n(h_sync_raw)
  );

  vga_axis #(.ACTIVE(V_ACTIVE), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .W(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .step(h_wrap),
    .pos(v_pos), .last(v_last), .active(v_act), .sync_n(v_sync_raw)
  );

  assign px_active = h_act && v_act;

  vga_fetch #(.HW(HW), .VW(VW), .ADDR_W(ADDR_W), .FB_BASE(FB_BASE),
              .ROW_STRIDE(ROW_STRIDE), .REP_LOG2(REP_LOG2)) u_fetch (
    .h_pos(h_pos), .v_pos(v_pos), .px_active(px_active),
    .mem_addr(mem_addr), .mem_en(mem_en)
  );

  vga_pixel_out u_out (
    .clk(clk), .rst_n(rst_n),
    .hs_in(h_sync_raw), .vs_in(v_sync_raw), .act_in(px_active),
    .mem_data(mem_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );
endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk #(
  parameter int H_TOTAL  = 800,
  parameter int H_SSTART = 656,
  parameter int HW       = 10,
  parameter int VW       = 10,
  parameter int ADDR_W   = 16,
  parameter int REP_LOG2 = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HW-1:0]     h_pos,
  input logic [VW-1:0]     v_pos,
  input logic              h_wrap,
  input logic              px_active,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en,
  input logic              hsync_n,
  input logic [1:0]        red,
  input logic [1:0]        green,
  input logic [1:0]        blue
);
  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (h_pos == '0));

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> (h_pos == $past(h_pos) + HW'(1)));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(v_pos));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(px_active, 2) |-> ({red, green, blue} == 6'd0));

  // R7
  repl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && (h_pos[REP_LOG2-1:0] != '0)) |-> $stable(mem_addr));

  // R3
  hsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> ($past(h_pos, 2) == HW'(H_SSTART)));
endmodule

bind vga_lowres_scan vga_scan_chk #(
  .H_TOTAL(H_ACTIVE + H_FP + H_SYNC + H_BP),
  .H_SSTART(H_ACTIVE + H_FP),
  .HW(HW), .VW(VW), .ADDR_W(ADDR_W), .REP_LOG2(REP_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos), .h_wrap(h_wrap),
  .px_active(px_active), .mem_addr(mem_addr), .mem_en(mem_en),
  .hsync_n(hsync_n), .red(red), .green(green), .blue(blue)
);

// File: tb/vga_lowres_scan_test.sv
module vga_lowres_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory content: upper bits vary so that ignoring them is exercised (R8).
  function automatic logic [7:0] memfn(input logic [15:0] a);
    return (a[7:0] * 8'd5) + a[15:8] + 8'h40;
  endfunction

  // Small configuration: 40 clocks x 20 lines.
  logic [15:0] s_addr, d_addr;
  logic        s_en, d_en, s_hs, s_vs, d_hs, d_vs;
  logic [1:0]  s_r, s_g, s_b, d_r, d_g, d_b;
  logic [7:0]  s_q, d_q;

  vga_lowres_scan #(.H_ACTIVE(32), .H_FP(2), .H_SYNC(4), .H_BP(2),
                    .V_ACTIVE(16), .V_FP(1), .V_SYNC(2), .V_BP(1)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(s_addr), .mem_en(s_en), .mem_data(s_q),
    .hsync_n(s_hs), .vsync_n(s_vs), .red(s_r), .green(s_g), .blue(s_b)
  );

  vga_lowres_scan uut_dflt (
    .clk(clk), .rst_n(rst_n), .mem_addr(d_addr), .mem_en(d_en), .mem_data(d_q),
    .hsync_n(d_hs), .vsync_n(d_vs), .red(d_r), .green(d_g), .blue(d_b)
  );

  always_ff @(posedge clk) begin
    s_q <= memfn(s_addr);
    d_q <= memfn(d_addr);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp, input int k);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, k, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input int h, input int v);
    return 16'('h0800 + (v / 4) * 'h100 + (h / 4));
  endfunction

  // Compare one configuration after clock edge k.
  task automatic cfg_check(input int k, input int ha, input int hf, input int hs, input int hb,
                           input int va, input int vf, input int vs, input int vb,
                           input logic ohs, input logic ovs, input logic [5:0] orgb,
                           input logic [15:0] oaddr, input logic oen);
    int ht, vt, p, h, v, ah, av;
    logic [7:0] d;
    logic       e_hs, e_vs, act;
    logic [5:0] e_rgb;
    ht = ha + hf + hs + hb;
    vt = va + vf + vs + vb;
    // Output side: position k-2 (R2), reset values before that (R1).
    if (k < 2) begin
      check(ohs == 1'b1, "R1", ohs, 1, k);
      check(ovs == 1'b1, "R1", ovs, 1, k);
      check(orgb == 6'd0, "R1", orgb, 0, k);
    end else begin
      p = k - 2;
      h = p % ht;
      v = (p / ht) % vt;
      act  = (h < ha) && (v < va);
      e_hs = !((h >= ha + hf) && (h < ha + hf + hs));
      e_vs = !((v >= va + vf) && (v < va + vf + vs));
      d = memfn(exp_addr(h, v));
      e_rgb = act ? {d[5:4], d[3:2], d[1:0]} : 6'd0;
      check(ohs == e_hs, "R3 R2", ohs, e_hs, k);
      check(ovs == e_vs, "R4 R2", ovs, e_vs, k);
      check(orgb == e_rgb, act ? "R8 R7" : "R5", orgb, e_rgb, k);
    end
    // Fetch side: counters at position k.
    ah = k % ht;
    av = (k / ht) % vt;
    check(oen == ((ah < ha) && (av < va)), "R9", oen, (ah < ha) && (av < va), k);
    if ((ah < ha) && (av < va))
      check(oaddr == exp_addr(ah, av), "R6 R7", oaddr, exp_addr(ah, av), k);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    check(s_hs && s_vs && ({s_r, s_g, s_b} == 6'd0), "R1", {s_hs, s_vs, s_r, s_g, s_b}, 'hC0, -1);
    check(d_hs && d_vs && ({d_r, d_g, d_b} == 6'd0), "R1", {d_hs, d_vs, d_r, d_g, d_b}, 'hC0, -1);
    rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      cfg_check(k, 32, 2, 4, 2, 16, 1, 2, 1, s_hs, s_vs, {s_b, s_g, s_r}, s_addr, s_en);
      cfg_check(k, 640, 16, 96, 48, 480, 10, 2, 33, d_hs, d_vs, {d_b, d_g, d_r}, d_addr, d_en);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule